// File: doc/BRIEF.md
# I2C Register-Bank Target with Auto-Incrementing Pointer

This block is an I2C target that gives a bus master access to a bank of 8-bit control registers, 256 entries by default. The bus lines SCL and SDA are sampled with a fast system clock through a short synchronizer. START and STOP conditions are recovered from the sampled levels. The first byte of each transfer is matched against a fixed 7-bit device address.

A write transfer first loads an internal pointer from the byte that follows the address. Each later byte is then stored at the pointer. A read transfer has no pointer phase: it returns bytes at once, starting from wherever the last write left the pointer. After every data byte, in either direction, the pointer advances by one and wraps at the end of the bank. SDA is modelled as an output-enable that pulls the line low. A low-active chip select gates the whole interface. The chip uses the register contents directly through a flat parallel output.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0x00 on the parallel output and SDA is not driven.
- R2: The first byte after START carries the device address 7'b1000000 in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). On a match the target pulls SDA low during the ninth SCL pulse.
- R3: On an address mismatch the target never drives SDA until the next START or STOP. Registers and pointer keep their values.
- R4: In a write, the second byte loads the pointer and is acknowledged. Each later complete byte is stored in register[pointer] and acknowledged.
- R5: The pointer advances by one after every data byte written or read, and wraps from 0xFF to 0x00.
- R6: In a read, the target shifts out register[pointer] MSB first, starting right after the address acknowledge, using the pointer left by the previous write.
- R7: A master acknowledge (SDA low on the ninth pulse) makes the target send the next register. A missing acknowledge makes it release SDA so the master can issue STOP.
- R8: A repeated START restarts address reception at any point. A STOP ends the transfer, and a byte cut short by STOP is discarded.
- R9: While cs_n is high the target ignores the bus and does not drive SDA from the following clock on.
- R10: The target changes sda_oe only while SCL is low.
- R11: Register i appears on reg_flat bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; high disables the interface |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_flat | output | 2048 | All registers, register i at bits [8i+7:8i] |

## Verification
The hardest state to reach from the pins is the pointer rollover inside a single burst, because it takes 256 consecutive data bytes. The stimulus writes the whole bank in one transfer starting at pointer 0, which leaves the pointer wrapped to 0. It then reads the whole bank back with no pointer phase. A short burst across 0xFE..0x00 followed by a pointer-less read checks where the pointer lands. Repeated START, a STOP in the middle of a byte, a foreign address and a deselected chip are each followed by a read. That read shows through the bus alone that the pointer was not disturbed.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } i2c_st_e;
endpackage

// File: rtl/i2creg_sync.sv
// Multi-flop synchronizer; exposes the settled level and its previous value.
module i2creg_sync #(
   parameter int STAGES = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic prev
);
   localparam int PIPE_W = STAGES + 1;

   logic [PIPE_W-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2creg_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {PIPE_W{RESET_VAL}};
      else        pipe <= {pipe[PIPE_W-2:0], d};
   end

   assign lvl  = pipe[STAGES-1];
   assign prev = pipe[STAGES];
endmodule

// File: rtl/i2creg_bank.sv
// Register bank: one write port, one combinational read port, flat view.
module i2creg_bank import i2creg_pkg::*; #(
   parameter int PTR_W = 8,
   localparam int DEPTH = 1 << PTR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [PTR_W-1:0]        waddr,
   input  logic [BYTE_W-1:0]       wdata,
   input  logic [PTR_W-1:0]        raddr,
   output logic [BYTE_W-1:0]       rdata,
   output logic [DEPTH*BYTE_W-1:0] flat
);
   logic [BYTE_W-1:0] mem [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  mem[i] <= '0;
            else if (we && waddr == PTR_W'(i))           mem[i] <= wdata;
         end
         assign flat[i*BYTE_W +: BYTE_W] = mem[i];
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/i2creg_fsm.sv
// Bus protocol sequencer: address match, pointer, write strobe, read shifter.
module i2creg_fsm import i2creg_pkg::*; #(
   parameter int         PTR_W    = 8,
   parameter logic [6:0] DEV_ADDR = 7'b1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic [PTR_W-1:0]  ptr,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              sda_drive,
   output i2c_st_e           st
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              rnw;
   logic              mack;
   logic              receiving;
   logic              full;

   assign receiving = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA);
   assign full      = (cnt == CNT_FULL);
   assign wr_en     = !cs_n && (st == ST_WDATA) && scl_fall && full;
   assign wr_byte   = sh;

   always_comb begin
      case (st)
         ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sda_drive = 1'b1;
         ST_RDATA:                              sda_drive = !sh[BYTE_W-1];
         default:                               sda_drive = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         sh   <= '0;
         rnw  <= 1'b0;
         mack <= 1'b0;
         ptr  <= '0;
      end else if (cs_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (bus_stop) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (bus_start) begin
         st  <= ST_ADDR;
         cnt <= '0;
      end else begin
         if (receiving) begin
            if (scl_rise && !full) begin
               sh  <= {sh[BYTE_W-2:0], sda_lvl};
               cnt <= cnt + 1'b1;
            end else if (scl_fall && full) begin
               cnt <= '0;
               case (st)
                  ST_ADDR: begin
                     if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                        st  <= ST_ADDR_ACK;
                        rnw <= sh[0];
                     end else begin
                        st  <= ST_IGNORE;
                     end
                  end
                  ST_SUB: begin
                     ptr <= sh[PTR_W-1:0];
                     st  <= ST_SUB_ACK;
                  end
                  default: begin
                     ptr <= ptr + 1'b1;
                     st  <= ST_WDATA_ACK;
                  end
               endcase
            end
         end else begin
            case (st)
               ST_ADDR_ACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rnw) begin
                     st <= ST_RDATA;
                     sh <= rd_byte;
                  end else begin
                     st <= ST_SUB;
                  end
               end
               ST_SUB_ACK, ST_WDATA_ACK: if (scl_fall) begin
                  st  <= ST_WDATA;
                  cnt <= '0;
               end
               ST_RDATA: if (scl_fall) begin
                  sh  <= {sh[BYTE_W-2:0], 1'b0};
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_LAST) begin
                     st  <= ST_RACK;
                     ptr <= ptr + 1'b1;
                  end
               end
               ST_RACK: begin
                  if (scl_rise) mack <= !sda_lvl;
                  if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        st <= ST_RDATA;
                        sh <= rd_byte;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target import i2creg_pkg::*; #(
   parameter int         PTR_W       = 8,
   parameter logic [6:0] DEV_ADDR    = 7'b1000000,
   parameter int         SYNC_STAGES = 2,
   localparam int        DEPTH       = 1 << PTR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   output logic [DEPTH*BYTE_W-1:0] reg_flat
);
   generate
      if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
         $error("i2c_regbank_target: PTR_W must be 1..8");
      end
   endgenerate

   logic scl_lvl, scl_prev, sda_lvl, sda_prev;
   logic scl_rise, scl_fall, bus_start, bus_stop;
   logic              bank_we;
   logic [BYTE_W-1:0] bank_wdata;
   logic [BYTE_W-1:0] bank_rdata;
   logic [PTR_W-1:0]  ptr;
   i2c_st_e           st;

   i2creg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .lvl(scl_lvl), .prev(scl_prev));

   i2creg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .lvl(sda_lvl), .prev(sda_prev));

   assign scl_rise  =  scl_lvl && !scl_prev;
   assign scl_fall  = !scl_lvl &&  scl_prev;
   assign bus_start =  scl_lvl &&  scl_prev &&  sda_prev && !sda_lvl;
   assign bus_stop  =  scl_lvl &&  scl_prev && !sda_prev &&  sda_lvl;

   i2creg_fsm #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .rd_byte(bank_rdata), .ptr(ptr), .wr_en(bank_we), .wr_byte(bank_wdata),
      .sda_drive(sda_oe), .st(st));

   i2creg_bank #(.PTR_W(PTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we), .waddr(ptr), .wdata(bank_wdata),
      .raddr(ptr), .rdata(bank_rdata), .flat(reg_flat));
endmodule

// File: rtl/i2creg_chk.sv
module i2creg_chk import i2creg_pkg::*; #(
   parameter int PTR_W = 8,
   localparam int DEPTH = 1 << PTR_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cs_n,
   input logic                    scl_lvl,
   input logic                    sda_oe,
   input logic                    we,
   input logic [PTR_W-1:0]        wptr,
   input logic [BYTE_W-1:0]       wdata,
   input logic [DEPTH*BYTE_W-1:0] regs,
   input i2c_st_e                 st
);
   logic [PTR_W-1:0]  last_ptr;
   logic [BYTE_W-1:0] slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_ptr <= '0;
      else        last_ptr <= wptr;
   end
   assign slot = regs[int'(last_ptr)*BYTE_W +: BYTE_W];

   a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !sda_oe);

   a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(cs_n)) |-> !scl_lvl);

   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> wptr == PTR_W'($past(wptr) + 1'b1));

   a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> slot == $past(wdata));

   a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_oe);

   a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_RACK && st == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_regbank_target i2creg_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
   .we(bank_we), .wptr(ptr), .wdata(bank_wdata), .regs(reg_flat), .st(st));

// File: tb/tb_i2c_regbank_target.sv
`timescale 1ns/1ps
module tb_i2c_regbank_target;
   localparam int Q = 5;
   localparam int N = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [N*8-1:0] reg_flat;
   wire  sda_bus = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   int oe_cnt = 0;
   int viol   = 0;
   logic oe_prev = 1'b0;
   logic [7:0] exp_mem [N];

   always #5 clk = ~clk;

   i2c_regbank_target dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .reg_flat(reg_flat));

   always @(negedge clk) begin
      #1;
      if (sda_oe) oe_cnt++;
      if (sda_oe != oe_prev && scl_m) viol++;
      oe_prev = sda_oe;
   end

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic chk_bank(string req);
      for (int i = 0; i < N; i++) chk(req, 32'(reg_flat[i*8 +: 8]), 32'(exp_mem[i]));
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic i2c_bit(input logic b, output logic r);
      sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) i2c_bit(b[i], r);
      i2c_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rbyte(input logic nack, output logic [7:0] d);
      logic r;
      for (int i = 0; i < 8; i++) begin
         i2c_bit(1'b1, r);
         d = {d[6:0], r};
      end
      i2c_bit(nack, r);
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      int oe_snap;
      int p;
      for (int i = 0; i < N; i++) exp_mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk_bank("R1 reset value");
      chk("R1 sda released", 32'(sda_oe), 0);

      // R2 R4 R11: full-bank burst write from pointer 0
      i2c_start();
      wbyte(8'h80, ack); chk("R2 address ack (write)", 32'(ack), 1);
      wbyte(8'h00, ack); chk("R4 pointer byte ack", 32'(ack), 1);
      for (int i = 0; i < N; i++) begin
         wbyte(pat(i), ack);
         chk("R4 data byte ack", 32'(ack), 1);
         exp_mem[i] = pat(i);
      end
      i2c_stop();
      chk_bank("R4 R11 burst contents");

      // R6 R5 R7: full read, pointer wrapped to 0 by the write burst
      i2c_start();
      wbyte(8'h81, ack); chk("R2 address ack (read)", 32'(ack), 1);
      for (int i = 0; i < N; i++) begin
         rbyte(i == N - 1, d);
         chk("R6 read data", 32'(d), 32'(exp_mem[i]));
      end
      chk("R7 released after nack", 32'(sda_oe), 0);
      i2c_stop();

      // R5: wrap inside a short write burst, then read from where it stopped
      i2c_start();
      wbyte(8'h80, ack);
      wbyte(8'hFE, ack);
      wbyte(8'hA1, ack); exp_mem[8'hFE] = 8'hA1;
      wbyte(8'hA2, ack); exp_mem[8'hFF] = 8'hA2;
      wbyte(8'hA3, ack); exp_mem[8'h00] = 8'hA3;
      i2c_stop();
      chk_bank("R5 wrap write contents");
      i2c_start();
      wbyte(8'h81, ack);
      rbyte(1'b0, d); chk("R5 pointer after wrap", 32'(d), 32'(exp_mem[1]));
      rbyte(1'b1, d); chk("R5 R7 acked read advances", 32'(d), 32'(exp_mem[2]));
      i2c_stop();
      p = 3;

      // R3: foreign address is ignored
      oe_snap = oe_cnt;
      i2c_start();
      wbyte(8'h82, ack); chk("R3 no ack on mismatch", 32'(ack), 0);
      wbyte(8'h00, ack); chk("R3 no ack after mismatch", 32'(ack), 0);
      wbyte(8'h99, ack); chk("R3 no ack after mismatch", 32'(ack), 0);
      i2c_stop();
      chk("R3 never drove", 32'(oe_cnt - oe_snap), 0);
      chk_bank("R3 registers unchanged");
      i2c_start();
      wbyte(8'h81, ack);
      rbyte(1'b1, d); chk("R3 pointer unchanged", 32'(d), 32'(exp_mem[p]));
      i2c_stop();
      p++;

      // R9: deselected chip ignores a full write
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      oe_snap = oe_cnt;
      i2c_start();
      wbyte(8'h80, ack); chk("R9 no ack while deselected", 32'(ack), 0);
      wbyte(8'h05, ack);
      wbyte(8'h55, ack);
      i2c_stop();
      chk("R9 never drove", 32'(oe_cnt - oe_snap), 0);
      cs_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_bank("R9 registers unchanged");
      i2c_start();
      wbyte(8'h81, ack);
      rbyte(1'b1, d); chk("R9 pointer unchanged", 32'(d), 32'(exp_mem[p]));
      i2c_stop();

      // R8: repeated START turns a write into a read at the new pointer
      i2c_start();
      wbyte(8'h80, ack);
      wbyte(8'h10, ack);
      i2c_start();
      wbyte(8'h81, ack); chk("R8 address ack after repeated start", 32'(ack), 1);
      rbyte(1'b1, d); chk("R8 read after repeated start", 32'(d), 32'(exp_mem[8'h10]));
      i2c_stop();

      // R8: STOP in the middle of a data byte discards it
      i2c_start();
      wbyte(8'h80, ack);
      wbyte(8'h20, ack);
      i2c_bit(1'b1, ack);
      i2c_bit(1'b0, ack);
      i2c_bit(1'b1, ack);
      i2c_stop();
      chk_bank("R8 partial byte discarded");
      i2c_start();
      wbyte(8'h81, ack);
      rbyte(1'b1, d); chk("R8 pointer from truncated write", 32'(d), 32'(exp_mem[8'h20]));
      i2c_stop();

      // R10: SDA drive only changed with SCL low
      chk("R10 drive change while SCL high", 32'(viol), 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule